// File: doc/BRIEF.md
# Console Terminal Register Block

This block connects a character keyboard and a character display to a processor through four 32-bit registers on a simple load/store bus. The registers occupy a 16-byte window at `BASE` (default 0xFFFF0000). Software either polls each direction's ready flag or enables an interrupt and waits for the level request. Reading the receive data register consumes the waiting character. Storing to the transmit data register starts a new character on the display.

On the device side, a receive port takes one character per cycle when its strobe is high. It never applies back-pressure: if a character arrives before software has read the previous one, the new character replaces it and the loss is recorded. The display port is a valid/ready stream. `disp_valid` stays high, with `disp_data` held steady, until the display raises `disp_ready`. The handshake completes on the clock edge where both signals are high. After each handshake the transmitter stays busy for `BUSY_CYC` clock cycles before it reports ready again. Each direction buffers one character.

Top module: `console_regs`

## Requirements
- R1: The registers decode from `bus_addr[3:2]` when `bus_addr[31:4]` equals `BASE[31:4]`: 0x0 is receive control, 0x4 is receive data, 0x8 is transmit control and 0xC is transmit data. Every request gets `bus_ack` in the following cycle, with `bus_rdata` valid in that cycle. An address outside the window reads as zero, and writing to it has no effect.
- R2: A control register returns Ready at bit 0 and interrupt enable at bit 1. The receive control register also returns overrun at bit 2. All other bits read as zero.
- R3: A character on `kb_valid`/`kb_data` sets receive Ready. A read of receive data then returns that character in bits 7:0, with bits 31:8 at zero.
- R4: A load from the receive data register clears receive Ready. If a character arrives in the same cycle, Ready stays 1 and the new character is kept. The load itself returns the older character.
- R5: A character that arrives while receive Ready is 1 (and no data read occurs in that cycle) replaces the held character and sets the sticky overrun flag. A read of receive control returns the flag and then clears it.
- R6: A store to transmit data while transmit Ready is 1 presents `bus_wdata[7:0]` on `disp_data` with `disp_valid` high, starting in the next cycle, and clears transmit Ready.
- R7: While `disp_valid` is high and `disp_ready` is low, `disp_valid` and `disp_data` stay unchanged.
- R8: Transmit Ready returns to 1 exactly `BUSY_CYC` clock cycles after the edge that completes the display handshake.
- R9: A store to transmit data while transmit Ready is 0 is ignored.
- R10: Bit 1 of each control register can be written by software. Ready and overrun cannot be written. Stores to the receive data register have no effect.
- R11: `irq` is the OR of (receive enable AND receive Ready) and (transmit enable AND transmit Ready). It stays high as long as either term holds.
- R12: After reset, receive Ready, overrun and both enables are 0, transmit Ready is 1, `disp_valid` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid when bus_ack is high |
| bus_ack | output | 1 | Response strobe, one cycle after bus_req |
| kb_valid | input | 1 | Incoming character strobe (always accepted) |
| kb_data | input | 8 | Incoming character |
| disp_valid | output | 1 | Outgoing character valid |
| disp_data | output | 8 | Outgoing character |
| disp_ready | input | 1 | Display accepts the character |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach are collisions within a single cycle. One is a keyboard character arriving on the same edge as a load from receive data. Another is a second character arriving before the first has been read. The bench drives the strobe and the bus request on the same falling edge to create these collisions. It then reads the control and data registers to see which character survived and whether overrun was recorded. The transmit busy window is measured one cycle at a time by enabling the transmit interrupt and watching `irq` after a handshake that the bench delays.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [1:0] {
    SEL_RX_CTL = 2'd0,
    SEL_RX_DAT = 2'd1,
    SEL_TX_CTL = 2'd2,
    SEL_TX_DAT = 2'd3
  } reg_sel_e;

  localparam int FLAG_RDY = 0;
  localparam int FLAG_IE  = 1;
  localparam int FLAG_OVR = 2;
endpackage

// File: rtl/con_rx_chan.sv
module con_rx_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              rd_data_stb,
  input  logic              rd_ctl_stb,
  input  logic              ie_wr_stb,
  input  logic              ie_wr_val,
  output logic              ready,
  output logic              ie,
  output logic              ovr,
  output logic [CHAR_W-1:0] data
);
  logic lost;
  assign lost = in_valid && ready && !rd_data_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      ie    <= 1'b0;
      ovr   <= 1'b0;
      data  <= '0;
    end else begin
      if (in_valid) begin
        data  <= in_data;
        ready <= 1'b1;
      end else if (rd_data_stb) begin
        ready <= 1'b0;
      end
      if (rd_ctl_stb) ovr <= 1'b0;
      if (lost)       ovr <= 1'b1;
      if (ie_wr_stb)  ie  <= ie_wr_val;
    end
  end

  // R3
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ready && data == $past(in_data));
  // R4
  rx_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_stb && !in_valid |=> !ready);
  // R5
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ready && !rd_data_stb |=> ovr);
endmodule

// File: rtl/con_tx_chan.sv
module con_tx_chan #(
  parameter int CHAR_W   = 8,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_stb,
  input  logic [CHAR_W-1:0] store_data,
  input  logic              ie_wr_stb,
  input  logic              ie_wr_val,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  input  logic              out_ready,
  output logic              ready,
  output logic              ie
);
  localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

  logic             waiting;
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign ready = !out_valid && !waiting;
  assign take  = store_stb && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      waiting   <= 1'b0;
      cnt       <= '0;
      ie        <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= store_data;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        waiting   <= 1'b1;
        cnt       <= CNT_W'(BUSY_CYC - 1);
      end else if (waiting) begin
        if (cnt == '0) waiting <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
      if (ie_wr_stb) ie <= ie_wr_val;
    end
  end

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R6
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb && ready |=> out_valid && out_data == $past(store_data));
  // R9
  tx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb && !ready && out_valid && !out_ready |=> $stable(out_data));
endmodule

// File: rtl/con_irq_merge.sv
module con_irq_merge #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_rdy,
  input  logic [N_SRC-1:0] src_en,
  output logic             irq
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = src_rdy[i] & src_en[i];
  end

  assign irq = |hit;

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (src_rdy & src_en) != '0);
endmodule

// File: rtl/console_regs.sv
module console_regs
  import console_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          CHAR_W   = 8,
  parameter int          BUSY_CYC = 8,
  parameter logic [31:0] BASE     = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_data,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_data,
  input  logic              disp_ready,
  output logic              irq
);
  localparam int WIN_LSB = 4;

  logic     hit;
  reg_sel_e sel;
  logic     rd, wr;
  logic     rx_rdy, rx_ie, rx_ovr, tx_rdy, tx_ie;
  logic [CHAR_W-1:0] rx_data;
  logic [DATA_W-1:0] rd_mux;
  logic unused_bits;

  assign hit = bus_req && (bus_addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
  assign sel = reg_sel_e'(bus_addr[3:2]);
  assign rd  = hit && !bus_we;
  assign wr  = hit && bus_we;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CHAR_W], bus_wdata[0]};

  con_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (kb_valid),
    .in_data    (kb_data),
    .rd_data_stb(rd && sel == SEL_RX_DAT),
    .rd_ctl_stb (rd && sel == SEL_RX_CTL),
    .ie_wr_stb  (wr && sel == SEL_RX_CTL),
    .ie_wr_val  (bus_wdata[FLAG_IE]),
    .ready      (rx_rdy),
    .ie         (rx_ie),
    .ovr        (rx_ovr),
    .data       (rx_data)
  );

  con_tx_chan #(.CHAR_W(CHAR_W), .BUSY_CYC(BUSY_CYC)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .store_stb (wr && sel == SEL_TX_DAT),
    .store_data(bus_wdata[CHAR_W-1:0]),
    .ie_wr_stb (wr && sel == SEL_TX_CTL),
    .ie_wr_val (bus_wdata[FLAG_IE]),
    .out_valid (disp_valid),
    .out_data  (disp_data),
    .out_ready (disp_ready),
    .ready     (tx_rdy),
    .ie        (tx_ie)
  );

  con_irq_merge #(.N_SRC(2)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_rdy({tx_rdy, rx_rdy}),
    .src_en ({tx_ie, rx_ie}),
    .irq    (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (rd) begin
      unique case (sel)
        SEL_RX_CTL: begin
          rd_mux[FLAG_RDY] = rx_rdy;
          rd_mux[FLAG_IE]  = rx_ie;
          rd_mux[FLAG_OVR] = rx_ovr;
        end
        SEL_RX_DAT: rd_mux[CHAR_W-1:0] = rx_data;
        SEL_TX_CTL: begin
          rd_mux[FLAG_RDY] = tx_rdy;
          rd_mux[FLAG_IE]  = tx_ie;
        end
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_rdata <= rd_mux;
    end
  end

  // R1
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);
  // R1
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_req));
  // R2
  rdata_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> bus_rdata[DATA_W-1:CHAR_W] == '0);
endmodule

// File: tb/console_regs_bench.sv
module console_regs_bench;
  localparam int BUSY = 6;
  localparam logic [31:0] B = 32'hFFFF_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_ack, kb_valid = 1'b0, disp_valid, disp_ready = 1'b0, irq;
  logic [7:0] kb_data = '0, disp_data;
  int n_run = 0, n_fail = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  console_regs #(.BUSY_CYC(BUSY)) u_console_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .kb_valid(kb_valid), .kb_data(kb_data),
    .disp_valid(disp_valid), .disp_data(disp_data), .disp_ready(disp_ready),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_req = 1'b0;
    check("R1 ack", {31'd0, bus_ack}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic key(input logic [7:0] c);
    @(negedge clk); kb_valid = 1'b1; kb_data = c;
    @(negedge clk); kb_valid = 1'b0;
  endtask

  task automatic t_reset();
    rd(B + 0, rv); check("R12 rx ctl", rv, 32'h0);
    rd(B + 8, rv); check("R12 tx ctl", rv, 32'h1);
    check("R12 disp_valid", {31'd0, disp_valid}, 0);
    check("R12 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_rx_basic();
    key(8'hA5);
    rd(B + 0, rv); check("R3 ready set", rv, 32'h1);
    rd(B + 4, rv); check("R3 data", rv, 32'h0000_00A5);
    rd(B + 0, rv); check("R4 ready cleared", rv, 32'h0);
  endtask

  task automatic t_rx_race();
    key(8'h11);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_addr = B + 4;
    kb_valid = 1'b1; kb_data = 8'h22;
    @(negedge clk); bus_req = 1'b0; kb_valid = 1'b0;
    check("R4 race old data", bus_rdata, 32'h11);
    rd(B + 0, rv); check("R4 race ready kept, no overrun", rv, 32'h1);
    rd(B + 4, rv); check("R4 race new data", rv, 32'h22);
  endtask

  task automatic t_overrun();
    key(8'h31); key(8'h32);
    rd(B + 0, rv); check("R5 overrun seen", rv, 32'h5);
    rd(B + 0, rv); check("R5 overrun cleared", rv, 32'h1);
    rd(B + 4, rv); check("R5 newest kept", rv, 32'h32);
  endtask

  task automatic t_ctrl_write();
    wr(B + 0, 32'hFFFF_FFFF);
    rd(B + 0, rv); check("R10 only IE writable", rv, 32'h2);
    wr(B + 4, 32'h77);
    rd(B + 0, rv); check("R10 rx data store ignored", rv, 32'h2);
    wr(B + 0, 32'h0);
    wr(B + 8, 32'hFFFF_FFFC);
    rd(B + 8, rv); check("R10 tx ready not writable", rv, 32'h1);
    wr(B + 8, 32'h0);
  endtask

  task automatic t_outside();
    wr(32'hFFFE_000C, 32'h41);
    check("R1 outside no store", {31'd0, disp_valid}, 0);
    wr(32'hFFFF_0010, 32'h42);
    check("R1 outside no store 2", {31'd0, disp_valid}, 0);
    key(8'h5A);
    rd(32'hFFFF_0014, rv); check("R1 outside reads 0", rv, 32'h0);
    rd(B + 0, rv); check("R1 outside no side effect", rv, 32'h1);
    rd(B + 4, rv);
  endtask

  task automatic t_tx_timing();
    wr(B + 8, 32'h2);
    check("R11 tx irq", {31'd0, irq}, 1);
    wr(B + 12, 32'hABCD_EF4C);
    check("R6 valid", {31'd0, disp_valid}, 1);
    check("R6 byte", {24'd0, disp_data}, 32'h4C);
    check("R6 irq dropped", {31'd0, irq}, 0);
    wr(B + 12, 32'h99);
    repeat (3) @(negedge clk);
    check("R7 held valid", {31'd0, disp_valid}, 1);
    check("R9 ignored store", {24'd0, disp_data}, 32'h4C);
    disp_ready = 1'b1;
    @(negedge clk); disp_ready = 1'b0;
    check("R7 handshake done", {31'd0, disp_valid}, 0);
    for (int n = 1; n <= BUSY; n++) begin
      check("R8 still busy", {31'd0, irq}, 0);
      @(negedge clk);
    end
    check("R8 ready after busy", {31'd0, irq}, 1);
    rd(B + 8, rv); check("R8 tx ctl", rv, 32'h3);
    wr(B + 8, 32'h0);
  endtask

  task automatic t_irq_rx();
    wr(B + 0, 32'h2);
    check("R11 idle no irq", {31'd0, irq}, 0);
    key(8'h61);
    check("R11 rx irq", {31'd0, irq}, 1);
    repeat (2) @(negedge clk);
    check("R11 level held", {31'd0, irq}, 1);
    rd(B + 4, rv);
    check("R11 cleared by read", {31'd0, irq}, 0);
    wr(B + 0, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rx_basic();
    t_rx_race();
    t_overrun();
    t_ctrl_write();
    t_outside();
    t_tx_timing();
    t_irq_rx();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule